// File: doc/BRIEF.md
# Line-21 Closed Caption Encoder

This block places caption or extended-data characters on one selectable video line per field. It produces a luma sample stream to drive the luminance path. Each field has its own pair of 7-bit characters. The block prefixes each pair with a clock run-in and a start code, and adds an odd parity bit to every character. The result is sent as a two-level waveform at 32 bit periods per line.

A fractional phase accumulator derives the bit timing from the pixel clock. Exactly 64 half-bit steps fit into one line. The same 32x ratio holds when the line length is switched between the 60 Hz and 50 Hz sample counts.

The line number counts from 1 at the first horizontal sync after the field identifier changes. The selected line is clamped to a parameterised window. On that line the block raises an override flag, which the surrounding encoder uses to replace its normal luma with this block's output. The characters are captured at the start of the line, so a write made while a line is being sent affects only later fields.

Top module: `cc_line_encoder`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `luma_out` equals the blanking level (parameter `LVL_BLANK`, default 240) and `cc_active` is 0.
- R2: The line counter is set to 1 on an `hsync` edge where `field_id` differs from its value at the previous `hsync` edge, and is otherwise increased by 1. `cc_active` is 1 for exactly the line whose count equals the effective target line. It rises one clock after that line's `hsync` edge and falls one clock after the next `hsync` edge.
- R3: The effective target line is `line_sel` clamped to the range `LINE_MIN`..`LINE_MAX` (defaults 10..25).
- R4: A line has 64 half-bit steps. The step index is floor(k*64/L), where k counts the clocks since the `hsync` edge and L is `SPL_60` when `rate_50`=0 or `SPL_50` when `rate_50`=1. `rate_50` may change only together with `hsync`.
- R5: Bit slot n covers half-bit steps 2n and 2n+1. The frame begins at slot `START_SLOT` (default 4) with 7 run-in bits. Each run-in bit is high on its first half and low on its second half.
- R6: The run-in is followed by three start bits with the values 0, 0, 1 in that order.
- R7: Next come the first character and then the second. Each character is sent as its 7 bits starting with bit 0, followed by a parity bit chosen so that the 8 bits hold an odd number of ones.
- R8: `f0_first`/`f0_second` are sent when `field_id` is 0 at the line's `hsync` edge, and `f1_first`/`f1_second` are sent when it is 1.
- R9: A data low is output as `LVL_BLANK`, and a data high as `LVL_HIGH` (default 520, about 50 IRE).
- R10: The characters are captured at the target line's `hsync` edge. A change on the character inputs during the line does not alter the waveform of that line.
- R11: When `field_en[field_id]` is 0 at the target line's `hsync` edge, `cc_active` is still 1 for that line, but `luma_out` stays at `LVL_BLANK` throughout it.
- R12: Outside the 26 frame slots, and before the first `hsync` after reset, `luma_out` is `LVL_BLANK`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync | input | 1 | One-clock pulse marking the first sample of a line |
| field_id | input | 1 | Field identifier, sampled at `hsync` |
| rate_50 | input | 1 | 1 selects the 50 Hz line length |
| line_sel | input | LSEL_W (5) | Requested caption line |
| field_en | input | 2 | Per-field encode enable, bit index = field |
| f0_first | input | 7 | First character for field 0 |
| f0_second | input | 7 | Second character for field 0 |
| f1_first | input | 7 | First character for field 1 |
| f1_second | input | 7 | Second character for field 1 |
| luma_out | output | LUMA_W (10) | Caption luma sample |
| cc_active | output | 1 | Luma override flag for the caption line |

## Verification
Two events can share one clock edge: a character write and the capture edge of the line that uses it. A write can also land in the middle of a line that is being sent. The bench changes the field-0 characters 80 clocks into a target line. It then compares every sample against a model that froze the old characters at that line's `hsync`, and requires the new characters on the next field-0 line. The second case is a `rate_50` change that arrives with the `hsync` pulse which restarts the phase accumulator. The bench checks that the next line's step positions follow the new line length from its first sample.

// File: rtl/cc_pkg.sv
// Package cc_pkg
// Shared constants and helpers for the caption line encoder.
// Assumes a frame of run-in, start code and two 8-bit character slots.
package cc_pkg;
    localparam int RUNIN_BITS = 7;
    localparam int START_BITS = 3;
    localparam int CHAR_BITS  = 7;
    localparam int CHAR_SLOTS = CHAR_BITS + 1;
    localparam int FRAME_BITS = RUNIN_BITS + START_BITS + 2 * CHAR_SLOTS;

    typedef enum logic [1:0] {
        SEG_IDLE,
        SEG_RUNIN,
        SEG_START,
        SEG_CHAR
    } seg_e;

    // Parity bit that makes the 8-bit character word hold an odd number of ones.
    function automatic logic odd_parity(input logic [CHAR_BITS-1:0] d);
        return ~^d;
    endfunction
endpackage

// File: rtl/cc_halfbit_clock.sv
// Module cc_halfbit_clock
// Fractional phase accumulator: it adds TICKS per pixel clock modulo the
// line length, so that exactly TICKS half-bit steps occur per line.
// Assumes the line length is at least TICKS, so at most one step happens
// per clock. It restarts at every line start. The index saturates at its
// maximum, which is also its reset value, so that nothing is sent before
// the first line.
module cc_halfbit_clock #(
    parameter int SPL_60 = 858,
    parameter int SPL_50 = 864,
    parameter int TICKS  = 64,
    parameter int HB_W   = $clog2(TICKS) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_start,
    input  logic            rate_50,
    output logic [HB_W-1:0] hb
);
    localparam int SPL_MAX = (SPL_60 > SPL_50) ? SPL_60 : SPL_50;
    localparam int ACC_W   = $clog2(SPL_MAX + TICKS + 1);
    localparam logic [HB_W-1:0] HB_MAX = '1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] modulus;

    // Select the line length and form the next phase value.
    always_comb begin
        modulus = rate_50 ? ACC_W'(SPL_50) : ACC_W'(SPL_60);
        acc_sum = acc + ACC_W'(TICKS);
    end

    // Advance the phase and step the half-bit index on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            hb  <= HB_MAX;
        end else if (line_start) begin
            acc <= '0;
            hb  <= '0;
        end else if (acc_sum >= modulus) begin
            acc <= acc_sum - modulus;
            if (hb != HB_MAX) hb <= hb + 1'b1;
        end else begin
            acc <= acc_sum;
        end
    end

    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (hb == '0));

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && hb != HB_MAX) |=> ((hb - $past(hb)) <= HB_W'(1)));

    a_r4_phase_below_length: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> (acc < modulus || hb == '0));
endmodule

// File: rtl/cc_line_tracker.sv
// Module cc_line_tracker
// Counts lines within a field. The count restarts at 1 when the field
// identifier changes between line starts. The module flags the line that
// matches the target and captures that field's enable bit.
// Assumes hsync is a one-clock pulse at the first sample of each line.
module cc_line_tracker #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              field_id,
    input  logic [LINE_W-1:0] target_line,
    input  logic [1:0]        field_en,
    output logic              line_hit,
    output logic              line_en
);
    localparam logic [LINE_W-1:0] LINE_TOP = '1;

    logic              field_q;
    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] next_line;

    // Next line number: restart on a field change, else count up and saturate.
    always_comb begin
        if (field_id != field_q)
            next_line = LINE_W'(1);
        else if (line_cnt == LINE_TOP)
            next_line = line_cnt;
        else
            next_line = line_cnt + 1'b1;
    end

    // Update the count, the target match and the enable at each line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q  <= 1'b0;
            line_cnt <= '0;
            line_hit <= 1'b0;
            line_en  <= 1'b0;
        end else if (hsync) begin
            field_q  <= field_id;
            line_cnt <= next_line;
            line_hit <= (next_line == target_line);
            line_en  <= field_en[field_id];
        end
    end

    a_r2_first_line: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync && field_id != field_q) |=> (line_cnt == LINE_W'(1)));

    a_r2_hit_moves_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync |=> ($stable(line_hit) && $stable(line_en)));

    a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync && field_id == field_q && line_cnt != LINE_TOP) |=> (line_cnt == $past(line_cnt) + 1'b1));
endmodule

// File: rtl/cc_wave_shaper.sv
// Module cc_wave_shaper
// Captures the selected field's characters at each line start. It maps the
// half-bit index onto the frame (run-in, start code, two characters with
// odd parity) and registers the resulting two-level luma sample.
// Assumes START_SLOT + FRAME_BITS fits in the 32 bit slots of a line.
module cc_wave_shaper #(
    parameter int LUMA_W     = 10,
    parameter int LVL_BLANK  = 240,
    parameter int LVL_HIGH   = 520,
    parameter int HB_W       = 7,
    parameter int START_SLOT = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hsync,
    input  logic                          field_id,
    input  logic [cc_pkg::CHAR_BITS-1:0]  f0_first,
    input  logic [cc_pkg::CHAR_BITS-1:0]  f0_second,
    input  logic [cc_pkg::CHAR_BITS-1:0]  f1_first,
    input  logic [cc_pkg::CHAR_BITS-1:0]  f1_second,
    input  logic [HB_W-1:0]               hb,
    input  logic                          line_hit,
    input  logic                          line_en,
    output logic [LUMA_W-1:0]             luma,
    output logic                          active
);
    import cc_pkg::*;

    localparam logic signed [7:0] RUN_END   = 8'(RUNIN_BITS);
    localparam logic signed [7:0] START_END = 8'(RUNIN_BITS + START_BITS);
    localparam logic signed [7:0] FRAME_END = 8'(FRAME_BITS);
    localparam logic [LUMA_W-1:0] Y_LOW     = LUMA_W'(LVL_BLANK);
    localparam logic [LUMA_W-1:0] Y_HIGH    = LUMA_W'(LVL_HIGH);

    logic [CHAR_BITS-1:0]  sh_first;
    logic [CHAR_BITS-1:0]  sh_second;
    logic [CHAR_SLOTS-1:0] w_first;
    logic [CHAR_SLOTS-1:0] w_second;
    logic [HB_W-2:0]       slot;
    logic signed [7:0]     rel;
    logic [7:0]            idx;
    seg_e                  seg;
    logic                  data_bit;

    // Capture the characters of the arriving field at the line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_first  <= '0;
            sh_second <= '0;
        end else if (hsync) begin
            sh_first  <= field_id ? f1_first  : f0_first;
            sh_second <= field_id ? f1_second : f0_second;
        end
    end

    // Append the parity bit to each captured character.
    always_comb begin
        w_first  = {odd_parity(sh_first),  sh_first};
        w_second = {odd_parity(sh_second), sh_second};
    end

    // Locate the current bit slot relative to the frame start.
    always_comb begin
        slot = hb[HB_W-1:1];
        rel  = $signed(8'(slot)) - $signed(8'(START_SLOT));
        idx  = 8'(rel - START_END);
    end

    // Choose the frame segment and the bit value it sends.
    always_comb begin
        seg      = SEG_IDLE;
        data_bit = 1'b0;
        if (!rel[7]) begin
            if (rel < RUN_END) begin
                seg      = SEG_RUNIN;
                data_bit = ~hb[0];
            end else if (rel < START_END) begin
                seg      = SEG_START;
                data_bit = (rel == START_END - 8'sd1);
            end else if (rel < FRAME_END) begin
                seg      = SEG_CHAR;
                data_bit = idx[3] ? w_second[idx[2:0]] : w_first[idx[2:0]];
            end
        end
    end

    // Register the luma sample and the override flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            luma   <= Y_LOW;
            active <= 1'b0;
        end else begin
            luma   <= (line_hit && line_en && data_bit) ? Y_HIGH : Y_LOW;
            active <= line_hit;
        end
    end

    a_r9_two_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (luma == Y_LOW || luma == Y_HIGH));

    a_r11_disabled_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (line_hit && !line_en) |=> (luma == Y_LOW));

    a_r10_capture_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync |=> ($stable(sh_first) && $stable(sh_second)));

    a_r12_idle_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == SEG_IDLE) |=> (luma == Y_LOW));

    a_r5_runin_second_half: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == SEG_RUNIN && hb[0]) |=> (luma == Y_LOW));
endmodule

// File: rtl/cc_line_encoder.sv
// Module cc_line_encoder
// Top of the caption line encoder. It clamps the requested line and
// connects the line tracker, the half-bit clock and the wave shaper.
// Assumes a single pixel-clock domain and a one-clock hsync pulse. The
// rate select may change only together with hsync.
module cc_line_encoder #(
    parameter int LUMA_W        = 10,
    parameter int LVL_BLANK     = 240,
    parameter int LVL_HIGH      = 520,
    parameter int SPL_60        = 858,
    parameter int SPL_50        = 864,
    parameter int BITS_PER_LINE = 32,
    parameter int START_SLOT    = 4,
    parameter int LINE_W        = 10,
    parameter int LSEL_W        = 5,
    parameter int LINE_MIN      = 10,
    parameter int LINE_MAX      = 25
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hsync,
    input  logic                          field_id,
    input  logic                          rate_50,
    input  logic [LSEL_W-1:0]             line_sel,
    input  logic [1:0]                    field_en,
    input  logic [cc_pkg::CHAR_BITS-1:0]  f0_first,
    input  logic [cc_pkg::CHAR_BITS-1:0]  f0_second,
    input  logic [cc_pkg::CHAR_BITS-1:0]  f1_first,
    input  logic [cc_pkg::CHAR_BITS-1:0]  f1_second,
    output logic [LUMA_W-1:0]             luma_out,
    output logic                          cc_active
);
    localparam int TICKS = 2 * BITS_PER_LINE;
    localparam int HB_W  = $clog2(TICKS) + 1;

    logic [LINE_W-1:0] sel_ext;
    logic [LINE_W-1:0] eff_line;
    logic [HB_W-1:0]   hb;
    logic              line_hit;
    logic              line_en;

    // Clamp the requested line into the permitted window.
    always_comb begin
        sel_ext = LINE_W'(line_sel);
        if (sel_ext < LINE_W'(LINE_MIN))
            eff_line = LINE_W'(LINE_MIN);
        else if (sel_ext > LINE_W'(LINE_MAX))
            eff_line = LINE_W'(LINE_MAX);
        else
            eff_line = sel_ext;
    end

    cc_line_tracker #(
        .LINE_W (LINE_W)
    ) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync       (hsync),
        .field_id    (field_id),
        .target_line (eff_line),
        .field_en    (field_en),
        .line_hit    (line_hit),
        .line_en     (line_en)
    );

    cc_halfbit_clock #(
        .SPL_60 (SPL_60),
        .SPL_50 (SPL_50),
        .TICKS  (TICKS),
        .HB_W   (HB_W)
    ) u_bitclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (hsync),
        .rate_50    (rate_50),
        .hb         (hb)
    );

    cc_wave_shaper #(
        .LUMA_W     (LUMA_W),
        .LVL_BLANK  (LVL_BLANK),
        .LVL_HIGH   (LVL_HIGH),
        .HB_W       (HB_W),
        .START_SLOT (START_SLOT)
    ) u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync     (hsync),
        .field_id  (field_id),
        .f0_first  (f0_first),
        .f0_second (f0_second),
        .f1_first  (f1_first),
        .f1_second (f1_second),
        .hb        (hb),
        .line_hit  (line_hit),
        .line_en   (line_en),
        .luma      (luma_out),
        .active    (cc_active)
    );

    a_r2_blank_when_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_active |-> (luma_out == LUMA_W'(LVL_BLANK)));

    a_r3_target_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_line >= LINE_W'(LINE_MIN) && eff_line <= LINE_W'(LINE_MAX)));
endmodule

// File: tb/tb_cc_line_encoder.sv
// Bench for cc_line_encoder. A behavioural per-line waveform model, built
// as a 64-entry half-bit table at every line start, is compared with the
// outputs on every clock.
module tb_cc_line_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int SPL60      = 160;
    localparam int SPL50      = 170;
    localparam int BLANK      = 240;
    localparam int HIGH       = 520;
    localparam int START      = 4;
    localparam int LMIN       = 10;
    localparam int LMAX       = 25;
    localparam int LINES      = 27;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic       field_id = 1'b0;
    logic       rate_50 = 1'b0;
    logic [4:0] line_sel = 5'd21;
    logic [1:0] field_en = 2'b11;
    logic [6:0] f0_first = '0, f0_second = '0, f1_first = '0, f1_second = '0;
    logic [9:0] luma_out;
    logic       cc_active;

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    bit    want_rate = 1'b0;
    bit    mid_seen = 1'b0;

    // model state
    int    m_line = 0, m_fq = 0, m_k = 0;
    bit    m_on = 0, m_en = 0, m_started = 0, m_clamped = 0, m_f1 = 0;
    bit    m_wave [64];
    int    exp_luma = BLANK;
    bit    exp_act = 0;
    string exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_line_encoder #(
        .SPL_60     (SPL60),
        .SPL_50     (SPL50),
        .START_SLOT (START),
        .LINE_MIN   (LMIN),
        .LINE_MAX   (LMAX)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync     (hsync),
        .field_id  (field_id),
        .rate_50   (rate_50),
        .line_sel  (line_sel),
        .field_en  (field_en),
        .f0_first  (f0_first),
        .f0_second (f0_second),
        .f1_first  (f1_first),
        .f1_second (f1_second),
        .luma_out  (luma_out),
        .cc_active (cc_active)
    );

    // Fill the 64-entry half-bit table for one frame
    task automatic build_wave(input logic [6:0] c1, input logic [6:0] c2);
        int p;
        int ones;
        logic [6:0] ch;
        for (int i = 0; i < 64; i++) m_wave[i] = 1'b0;
        p = START * 2;
        for (int r = 0; r < 7; r++) begin
            m_wave[p] = 1'b1; m_wave[p+1] = 1'b0; p += 2;
        end
        m_wave[p] = 0; m_wave[p+1] = 0; p += 2;
        m_wave[p] = 0; m_wave[p+1] = 0; p += 2;
        m_wave[p] = 1; m_wave[p+1] = 1; p += 2;
        for (int c = 0; c < 2; c++) begin
            ch = (c == 0) ? c1 : c2;
            ones = 0;
            for (int b = 0; b < 7; b++) begin
                m_wave[p] = ch[b]; m_wave[p+1] = ch[b]; p += 2;
                ones += int'(ch[b]);
            end
            m_wave[p] = (ones % 2 == 0); m_wave[p+1] = (ones % 2 == 0); p += 2;
        end
    endtask

    // Reference model: expected outputs from the state before this edge
    always @(posedge clk) begin
        int hbm;
        int rel;
        int eff;
        int spl;
        bit hi;
        if (!rst_n) begin
            exp_luma = BLANK; exp_act = 0; exp_tag = "R1";
            m_line = 0; m_fq = 0; m_k = 0; m_on = 0; m_en = 0; m_started = 0;
        end else begin
            spl = rate_50 ? SPL50 : SPL60;
            hbm = m_started ? (m_k * 64) / spl : 99;
            hi  = (hbm < 64) ? m_wave[hbm] : 1'b0;
            exp_act  = m_on;
            exp_luma = (m_on && m_en && hi) ? HIGH : BLANK;
            rel = hbm / 2 - START;
            if (!m_on)                     exp_tag = "R2";
            else if (rel >= 0 && rel < 7)  exp_tag = "R5";
            else if (rel >= 7 && rel < 10) exp_tag = "R6";
            else if (rel >= 10 && rel < 26) exp_tag = "R7";
            else                           exp_tag = "R12";
            exp_tag = {exp_tag, "/R9"};
            if (m_clamped) exp_tag = {exp_tag, "/R3"};
            if (m_f1)      exp_tag = {exp_tag, "/R8"};
            if (!m_en)     exp_tag = {exp_tag, "/R11"};
            if (rate_50)   exp_tag = {exp_tag, "/R4"};
            if (mid_seen)  exp_tag = {exp_tag, "/R10"};
            if (hsync) begin
                m_started = 1;
                m_k = 0;
                if (int'(field_id) != m_fq) m_line = 1; else m_line++;
                m_fq = int'(field_id);
                eff = int'(line_sel);
                m_clamped = (eff < LMIN) || (eff > LMAX);
                if (eff < LMIN) eff = LMIN;
                if (eff > LMAX) eff = LMAX;
                m_on = (m_line == eff);
                m_en = field_en[field_id];
                m_f1 = field_id;
                if (field_id) build_wave(f1_first, f1_second);
                else          build_wave(f0_first, f0_second);
            end else begin
                m_k++;
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(luma_out) != exp_luma || cc_active !== exp_act) begin
                fails++;
                $display("FAIL %s t=%0t luma=%0d active=%0b expected luma=%0d active=%0b",
                         exp_tag, $time, luma_out, cc_active, exp_luma, exp_act);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R2 watchdog expired actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // One line: hsync on the first sample, optional character write mid-line
    task automatic drive_line(input bit fid, input bit mid);
        int spl;
        spl = want_rate ? SPL50 : SPL60;
        for (int s = 0; s < spl; s++) begin
            @(negedge clk);
            hsync = (s == 0);
            if (s == 0) begin
                field_id = fid;
                rate_50  = want_rate;
            end
            if (mid && s == 80) begin
                f0_first  = 7'h7F;
                f0_second = 7'h01;
                mid_seen  = 1'b1;
            end
        end
    endtask

    task automatic run_field(input bit fid, input bit mid);
        int eff;
        eff = int'(line_sel);
        if (eff < LMIN) eff = LMIN;
        if (eff > LMAX) eff = LMAX;
        for (int l = 1; l <= LINES; l++) drive_line(fid, mid && (l == eff));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;  // R1 reset values
        if (luma_out !== 10'(BLANK) || cc_active !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset luma=%0d active=%0b expected luma=%0d active=0",
                     luma_out, cc_active, BLANK);
        end
        rst_n = 1'b1;
        // R12: idle before the first hsync
        repeat (20) @(negedge clk);
        f0_first = 7'h41; f0_second = 7'h5A; f1_first = 7'h43; f1_second = 7'h00;
        run_field(1'b0, 1'b0);
        run_field(1'b1, 1'b0);       // R8 field 1 characters
        f1_first = 7'h2A; f1_second = 7'h55;
        run_field(1'b0, 1'b1);       // R10 write during the target line
        run_field(1'b1, 1'b0);
        run_field(1'b0, 1'b0);       // new field 0 characters take effect
        field_en = 2'b01;
        run_field(1'b1, 1'b0);       // R11 field 1 disabled
        field_en = 2'b10;
        run_field(1'b0, 1'b0);       // R11 field 0 disabled
        field_en = 2'b11;
        want_rate = 1'b1;            // R4 50 Hz line length
        run_field(1'b1, 1'b0);
        run_field(1'b0, 1'b0);
        line_sel = 5'd30;            // R3 clamp to the top of the window
        run_field(1'b1, 1'b0);
        line_sel = 5'd3;             // R3 clamp to the bottom of the window
        run_field(1'b0, 1'b0);
        want_rate = 1'b0;
        line_sel = 5'd14;
        run_field(1'b1, 1'b0);
        drive_line(1'b0, 1'b0);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule